// File: doc/BRIEF.md
# Multi-Converter DMA Result Packer

This block sits between a group of two or three analog-to-digital converters working in lockstep and a DMA engine. Each converter reports a 12-bit result with a one-cycle valid strobe. The block stores each result per converter and packs the results into 32-bit words in the layout set by a 2-bit packing mode. For each finished word it raises a DMA request. The word and the request are held until the DMA side acknowledges them.

There are three packing variants. Single mode sends one zero-extended result per word. Half-word pair mode puts two 12-bit results into the two 16-bit halves. Byte pair mode puts the low bytes of two results into the low 16 bits. With three converters, the pair modes walk a rotating sequence of converter pairs, so every result is used exactly once. A keep-going bit selects between two behaviours when the DMA reports its final transfer. The block can keep issuing requests, or it can go quiet until software writes mode 00 and then a nonzero mode again. An overrun flag records results that arrived while their converter still held an unused result.

Top module: `mdma_packer`

## Requirements
- R1: With mode 00 no request is ever raised and arriving results are dropped; the mode is never changed by the block.
- R2: Mode 01 emits one request per result, data = result in bits [11:0] with all other bits zero; with three converters the converter order is 1, 2, 3, repeating.
- R3: Mode 10 with three converters emits pairs in the repeating order (2,1), (1,3), (3,2). For pair (X,Y), Y's result occupies bits [11:0], X's result occupies bits [27:16], and all other bits are zero.
- R4: Mode 11 uses the R3 pair order, with Y's result bits [7:0] in word bits [7:0], X's result bits [7:0] in word bits [15:8], and bits [31:16] zero.
- R5: With two converters (triple low), modes 10 and 11 always pack pair (2,1), mode 01 alternates converter 1 then 2, and converter 3 strobes are ignored.
- R6: Once raised, the request and data word stay unchanged until acknowledged; a further word is loaded only after the acknowledge; after reset request, data and overrun are zero.
- R7: With keep-going low, a last-transfer pulse under a nonzero mode stops all new requests until the mode input has been 00 for at least one cycle and is then set nonzero.
- R8: With keep-going high, a last-transfer pulse has no effect on request generation.
- R9: A result arriving for a converter whose stored result has not yet been packed sets the overrun flag and is discarded; the flag stays set until a clear pulse, and a new overrun in the same cycle wins over the clear.
- R10: A change of the mode or of the converter count restarts the pair sequence at its first entry and discards stored, unpacked results.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| res_vld | input | 3 | Result strobe per converter, bit 0 = converter 1 |
| res_data | input | 36 | Results, converter n in bits [12n-1:12(n-1)] |
| mode | input | 2 | Packing mode: 00 off, 01 single, 10 half-word pairs, 11 byte pairs |
| keep_going | input | 1 | 1: ignore last-transfer; 0: stop after last transfer |
| triple | input | 1 | 1: three converters, 0: two |
| last_xfer | input | 1 | Pulse from DMA side marking its final transfer |
| req_ack | input | 1 | Acknowledge of the current request |
| ovr_clr | input | 1 | Pulse clearing the overrun flag |
| dma_req | output | 1 | DMA request, held until acknowledged |
| dma_data | output | 32 | Packed data word |
| ovr | output | 1 | Sticky overrun flag |

## Verification
The hardest state to reach from the ports is an overrun. An overrun needs a converter's stored result to still be waiting when that converter reports again. In normal flow the acknowledge arrives quickly, so each result is consumed within a few cycles. The bench therefore pauses its acknowledging monitor so that a word stays pending, then strobes the same converter twice. It then resumes and checks that the packed words held the first values, not the discarded one. The same stall is used to show that the pending word does not change while later results arrive.

// File: rtl/mdp_pkg.sv
// Shared definitions for the multi-converter DMA packer.
package mdp_pkg;
    localparam int NCONV = 3;

    typedef enum logic [1:0] {
        PK_OFF    = 2'd0,
        PK_SINGLE = 2'd1,
        PK_HALF   = 2'd2,
        PK_BYTE   = 2'd3
    } pk_mode_t;
endpackage

// File: rtl/mdp_hold.sv
// One converter's result store. Accepts a result when empty or when it is
// being consumed in the same cycle; flags a result that finds it occupied.
// Assumes take is only asserted while full.
module mdp_hold #(
    parameter int RES_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en,
    input  logic             flush,
    input  logic             vld,
    input  logic [RES_W-1:0] din,
    input  logic             take,
    output logic             full,
    output logic [RES_W-1:0] dout,
    output logic             ovr_hit
);
    // A strobe that finds the store occupied and not draining is an overrun.
    assign ovr_hit = vld && en && !flush && full && !take;

    // Store state: flush, consume, then capture.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            full <= 1'b0;
            dout <= '0;
        end else if (flush) begin
            full <= 1'b0;
        end else begin
            if (take) full <= 1'b0;
            if (vld && en && (!full || take)) begin
                full <= 1'b1;
                dout <= din;
            end
        end
    end
endmodule

// File: rtl/mdp_seq.sv
// Packing sequencer: tracks the position in the converter order and says
// which stores feed the next word (hi/lo) and which must be full.
// Assumes restart is raised whenever mode or triple changes.
module mdp_seq
    import mdp_pkg::*;
#(
    parameter int IDX_W = $clog2(NCONV)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  pk_mode_t         mode,
    input  logic             triple,
    input  logic             restart,
    input  logic             fire,
    output logic [NCONV-1:0] need,
    output logic [IDX_W-1:0] hi_idx,
    output logic [IDX_W-1:0] lo_idx,
    output logic             paired
);
    logic [IDX_W-1:0] step;
    logic [IDX_W-1:0] last;

    // Select sources for the current position.
    always_comb begin
        paired = (mode == PK_HALF) || (mode == PK_BYTE);
        if (triple)      last = IDX_W'(2);
        else if (paired) last = IDX_W'(0);
        else             last = IDX_W'(1);
        if (paired && triple) begin
            case (step)
                IDX_W'(0): begin hi_idx = IDX_W'(1); lo_idx = IDX_W'(0); end
                IDX_W'(1): begin hi_idx = IDX_W'(0); lo_idx = IDX_W'(2); end
                default:   begin hi_idx = IDX_W'(2); lo_idx = IDX_W'(1); end
            endcase
        end else if (paired) begin
            hi_idx = IDX_W'(1);
            lo_idx = IDX_W'(0);
        end else begin
            hi_idx = step;
            lo_idx = step;
        end
    end

    // Mask of stores that must hold a result before the word can go.
    generate
        for (genvar i = 0; i < NCONV; i++) begin : g_need
            assign need[i] = (lo_idx == IDX_W'(i)) || (paired && (hi_idx == IDX_W'(i)));
        end
    endgenerate

    // Position register: restart to the first entry, advance per word.
    always_ff @(posedge clk) begin
        if (!rst_n || restart) step <= '0;
        else if (fire)         step <= (step == last) ? '0 : step + IDX_W'(1);
    end
endmodule

// File: rtl/mdp_emit.sv
// Output stage: formats the word for the current mode and holds request and
// data until acknowledged. Assumes load is only raised while req is low,
// and 8 <= RES_W <= OUT_W/2.
module mdp_emit
    import mdp_pkg::*;
#(
    parameter int RES_W = 12,
    parameter int OUT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  pk_mode_t         mode,
    input  logic             paired,
    input  logic [RES_W-1:0] hi_val,
    input  logic [RES_W-1:0] lo_val,
    input  logic             ack,
    output logic             req,
    output logic [OUT_W-1:0] data
);
    localparam int HALF = OUT_W / 2;
    localparam int BYTE = 8;

    logic [OUT_W-1:0] word;

    // Lay out the results for the selected mode.
    always_comb begin
        word = '0;
        if (mode == PK_BYTE) begin
            word[BYTE-1:0]      = lo_val[BYTE-1:0];
            word[2*BYTE-1:BYTE] = hi_val[BYTE-1:0];
        end else begin
            word[RES_W-1:0] = lo_val;
            if (paired) word[HALF+RES_W-1:HALF] = hi_val;
        end
    end

    // Request handshake: load raises, acknowledge drops.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            req  <= 1'b0;
            data <= '0;
        end else if (load) begin
            req  <= 1'b1;
            data <= word;
        end else if (ack && req) begin
            req <= 1'b0;
        end
    end
endmodule

// File: rtl/mdma_packer.sv
// Multi-converter DMA result packer top. Stores per-converter results,
// packs them per the mode, raises a held DMA request per word, applies the
// stop-after-last-transfer rule and flags overruns.
// Assumes res_vld strobes are single-cycle and mode/triple are quasi-static.
module mdma_packer
    import mdp_pkg::*;
#(
    parameter int RES_W = 12,
    parameter int OUT_W = 32
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [NCONV-1:0]       res_vld,
    input  logic [NCONV*RES_W-1:0] res_data,
    input  logic [1:0]             mode,
    input  logic                   keep_going,
    input  logic                   triple,
    input  logic                   last_xfer,
    input  logic                   req_ack,
    input  logic                   ovr_clr,
    output logic                   dma_req,
    output logic [OUT_W-1:0]       dma_data,
    output logic                   ovr
);
    localparam int IDX_W = $clog2(NCONV);

    pk_mode_t         mode_e;
    pk_mode_t         mode_q;
    logic             triple_q;
    logic             armed;
    logic             active;
    logic             restart;
    logic             flush;
    logic             fire;
    logic             paired;
    logic [NCONV-1:0] need;
    logic [NCONV-1:0] full;
    logic [NCONV-1:0] take;
    logic [NCONV-1:0] ovr_hit;
    logic [IDX_W-1:0] hi_idx;
    logic [IDX_W-1:0] lo_idx;
    logic [RES_W-1:0] vals [NCONV];
    logic [RES_W-1:0] hi_val;
    logic [RES_W-1:0] lo_val;

    assign mode_e  = pk_mode_t'(mode);
    assign restart = (mode_e != mode_q) || (triple != triple_q);
    assign active  = (mode_e != PK_OFF) && armed;
    assign flush   = restart || !active;
    assign fire    = active && !restart && !dma_req && ((full & need) == need);
    assign take    = fire ? need : '0;

    // One store per converter; converter 3 only takes part in triple mode.
    generate
        for (genvar i = 0; i < NCONV; i++) begin : g_lane
            mdp_hold #(.RES_W(RES_W)) u_hold (
                .clk     (clk),
                .rst_n   (rst_n),
                .en      (active && ((i < 2) || triple)),
                .flush   (flush),
                .vld     (res_vld[i]),
                .din     (res_data[i*RES_W +: RES_W]),
                .take    (take[i]),
                .full    (full[i]),
                .dout    (vals[i]),
                .ovr_hit (ovr_hit[i])
            );
        end
    endgenerate

    // Route the selected stores to the formatter.
    always_comb begin
        hi_val = '0;
        lo_val = '0;
        for (int i = 0; i < NCONV; i++) begin
            if (hi_idx == IDX_W'(i)) hi_val = vals[i];
            if (lo_idx == IDX_W'(i)) lo_val = vals[i];
        end
    end

    mdp_seq #(.IDX_W(IDX_W)) u_seq (
        .clk     (clk),
        .rst_n   (rst_n),
        .mode    (mode_e),
        .triple  (triple),
        .restart (restart),
        .fire    (fire),
        .need    (need),
        .hi_idx  (hi_idx),
        .lo_idx  (lo_idx),
        .paired  (paired)
    );

    mdp_emit #(.RES_W(RES_W), .OUT_W(OUT_W)) u_emit (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (fire),
        .mode   (mode_e),
        .paired (paired),
        .hi_val (hi_val),
        .lo_val (lo_val),
        .ack    (req_ack),
        .req    (dma_req),
        .data   (dma_data)
    );

    // Remember configuration to detect changes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= PK_OFF;
            triple_q <= 1'b0;
        end else begin
            mode_q   <= mode_e;
            triple_q <= triple;
        end
    end

    // Re-arm rule: mode 00 re-arms, last transfer without keep-going disarms.
    always_ff @(posedge clk) begin
        if (!rst_n)                         armed <= 1'b1;
        else if (mode_e == PK_OFF)          armed <= 1'b1;
        else if (last_xfer && !keep_going)  armed <= 1'b0;
    end

    // Sticky overrun flag; a new overrun beats the clear.
    always_ff @(posedge clk) begin
        if (!rst_n)        ovr <= 1'b0;
        else if (|ovr_hit) ovr <= 1'b1;
        else if (ovr_clr)  ovr <= 1'b0;
    end
endmodule

// File: rtl/mdp_check.sv
// Protocol checker for mdma_packer, attached by bind.
module mdp_check #(
    parameter int OUT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic             keep_going,
    input logic             last_xfer,
    input logic             armed,
    input logic             dma_req,
    input logic [OUT_W-1:0] dma_data,
    input logic             req_ack,
    input logic             ovr,
    input logic             ovr_clr
);
    assert_off_no_req_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && !dma_req) |=> !dma_req);

    assert_req_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (dma_req && !req_ack) |=> (dma_req && $stable(dma_data)));

    assert_stop_disarms_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (last_xfer && !keep_going && mode != 2'b00) |=> !armed);

    assert_stopped_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!armed && mode != 2'b00 && !dma_req) |=> !dma_req);

    assert_keep_armed_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (keep_going && armed) |=> armed);

    assert_ovr_sticky_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (ovr && !ovr_clr) |=> ovr);
endmodule

bind mdma_packer mdp_check #(.OUT_W(OUT_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .mode       (mode),
    .keep_going (keep_going),
    .last_xfer  (last_xfer),
    .armed      (armed),
    .dma_req    (dma_req),
    .dma_data   (dma_data),
    .req_ack    (req_ack),
    .ovr        (ovr),
    .ovr_clr    (ovr_clr)
);

// File: tb/sim_mdma_packer.sv
// Scoreboard bench: driver tasks queue expected words, a monitor pops them.
module sim_mdma_packer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  res_vld = '0;
    logic [35:0] res_data = '0;
    logic [1:0]  mode = 2'b00;
    logic        keep_going = 1'b1;
    logic        triple = 1'b1;
    logic        last_xfer = 1'b0;
    logic        req_ack = 1'b0;
    logic        ovr_clr = 1'b0;
    logic        dma_req;
    logic [31:0] dma_data;
    logic        ovr;

    int          checks = 0;
    int          errors = 0;
    int          seen = 0;
    bit          mon_en = 1'b1;
    string       tag = "R6";
    logic [31:0] exp_q [$];

    always #5 clk = ~clk;

    mdma_packer u0 (
        .clk(clk), .rst_n(rst_n), .res_vld(res_vld), .res_data(res_data),
        .mode(mode), .keep_going(keep_going), .triple(triple),
        .last_xfer(last_xfer), .req_ack(req_ack), .ovr_clr(ovr_clr),
        .dma_req(dma_req), .dma_data(dma_data), .ovr(ovr)
    );

    function automatic logic [31:0] w_one(logic [11:0] v);
        return {20'h0, v};
    endfunction
    function automatic logic [31:0] w_half(logic [11:0] x, logic [11:0] y);
        return {4'h0, x, 4'h0, y};
    endfunction
    function automatic logic [31:0] w_byte(logic [11:0] x, logic [11:0] y);
        return {16'h0, x[7:0], y[7:0]};
    endfunction

    task automatic check(bit ok, string rq, logic [31:0] act, logic [31:0] expv);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", rq, act, expv);
        end
    endtask

    task automatic push(logic [31:0] w);
        exp_q.push_back(w);
    endtask

    // Strobe converter n (1..3) with value v, then leave a gap.
    task automatic send(int n, logic [11:0] v);
        @(negedge clk);
        res_vld[n-1] = 1'b1;
        res_data[(n-1)*12 +: 12] = v;
        @(negedge clk);
        res_vld = '0;
        repeat (4) @(negedge clk);
    endtask

    task automatic set_mode(logic [1:0] m);
        @(negedge clk);
        mode = m;
        repeat (2) @(negedge clk);
    endtask

    task automatic drain(string rq);
        repeat (20) @(negedge clk);
        check(exp_q.size() == 0, rq, 32'(exp_q.size()), 32'd0);
    endtask

    // Monitor: compare and acknowledge each request.
    initial begin
        logic [31:0] e;
        forever begin
            @(negedge clk);
            if (mon_en && dma_req) begin
                seen++;
                if (exp_q.size() == 0) begin
                    check(1'b0, {tag, " unexpected request"}, dma_data, 32'h0);
                end else begin
                    e = exp_q.pop_front();
                    check(dma_data == e, tag, dma_data, e);
                end
                req_ack = 1'b1;
                @(negedge clk);
                req_ack = 1'b0;
            end
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        int s0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(dma_req == 1'b0, "R6 reset req", 32'(dma_req), 32'd0);
        check(dma_data == 32'h0, "R6 reset data", dma_data, 32'h0);
        check(ovr == 1'b0, "R9 reset ovr", 32'(ovr), 32'd0);

        // R2: single results, order 1,2,3 twice
        tag = "R2";
        set_mode(2'b01);
        push(w_one(12'h111)); push(w_one(12'h222)); push(w_one(12'h333));
        push(w_one(12'hA01)); push(w_one(12'hA02)); push(w_one(12'hA03));
        send(1, 12'h111); send(2, 12'h222); send(3, 12'h333);
        send(1, 12'hA01); send(2, 12'hA02); send(3, 12'hA03);
        drain("R2");

        // R3: half-word pairs (2,1),(1,3),(3,2) over two rounds
        tag = "R3";
        set_mode(2'b10);
        push(w_half(12'h512, 12'h511));
        push(w_half(12'h521, 12'h513));
        push(w_half(12'h523, 12'h522));
        send(1, 12'h511); send(2, 12'h512); send(3, 12'h513);
        send(1, 12'h521); send(2, 12'h522); send(3, 12'h523);
        drain("R3");

        // R4: byte pairs, same rotation
        tag = "R4";
        set_mode(2'b11);
        push(w_byte(12'hF12, 12'hE11));
        push(w_byte(12'hC21, 12'hD13));
        push(w_byte(12'hB23, 12'hA22));
        send(1, 12'hE11); send(2, 12'hF12); send(3, 12'hD13);
        send(1, 12'hC21); send(2, 12'hA22); send(3, 12'hB23);
        drain("R4");

        // R10: mode change restarts sequence and drops the held result
        tag = "R10";
        set_mode(2'b10);
        push(w_half(12'h702, 12'h701));
        send(1, 12'h701); send(2, 12'h702); send(3, 12'h703);
        drain("R10");
        set_mode(2'b11);
        push(w_byte(12'h0C2, 12'h0C1));
        send(1, 12'h0C1); send(2, 12'h0C2);
        drain("R10");
        check(ovr == 1'b0, "R10 no stale store", 32'(ovr), 32'd0);

        // R5: dual converters
        tag = "R5";
        triple = 1'b0;
        set_mode(2'b10);
        s0 = seen;
        push(w_half(12'h822, 12'h811));
        send(1, 12'h811); send(2, 12'h822); send(3, 12'h833);
        drain("R5");
        check(seen == s0 + 1, "R5 dual pair count", 32'(seen - s0), 32'd1);
        set_mode(2'b01);
        push(w_one(12'h901)); push(w_one(12'h902)); push(w_one(12'h911));
        send(1, 12'h901); send(2, 12'h902); send(3, 12'h903); send(1, 12'h911);
        drain("R5");
        triple = 1'b1;

        // R1: mode 00 produces nothing
        tag = "R1";
        set_mode(2'b00);
        s0 = seen;
        send(1, 12'h101); send(2, 12'h102); send(3, 12'h103);
        repeat (10) @(negedge clk);
        check(seen == s0, "R1 no request", 32'(seen - s0), 32'd0);
        check(mode == 2'b00 && dma_req == 1'b0, "R1 req low", 32'(dma_req), 32'd0);

        // R7: stop after last transfer, re-arm through mode 00
        tag = "R7";
        keep_going = 1'b0;
        set_mode(2'b01);
        push(w_one(12'h201));
        send(1, 12'h201);
        drain("R7");
        @(negedge clk); last_xfer = 1'b1;
        @(negedge clk); last_xfer = 1'b0;
        s0 = seen;
        send(2, 12'h202); send(3, 12'h203); send(1, 12'h204);
        repeat (10) @(negedge clk);
        check(seen == s0, "R7 stopped", 32'(seen - s0), 32'd0);
        set_mode(2'b00);
        set_mode(2'b01);
        push(w_one(12'h205));
        send(1, 12'h205);
        drain("R7");

        // R8: keep-going ignores last transfer
        tag = "R8";
        keep_going = 1'b1;
        set_mode(2'b00);
        set_mode(2'b01);
        @(negedge clk); last_xfer = 1'b1;
        @(negedge clk); last_xfer = 1'b0;
        push(w_one(12'h301)); push(w_one(12'h302)); push(w_one(12'h303));
        send(1, 12'h301); send(2, 12'h302); send(3, 12'h303);
        drain("R8");

        // R6: held word while acknowledge is withheld
        tag = "R6";
        set_mode(2'b00);
        set_mode(2'b01);
        mon_en = 1'b0;
        push(w_one(12'h401)); push(w_one(12'h402)); push(w_one(12'h403));
        send(1, 12'h401);
        check(dma_req == 1'b1, "R6 req up", 32'(dma_req), 32'd1);
        check(dma_data == w_one(12'h401), "R6 data", dma_data, w_one(12'h401));
        send(2, 12'h402);
        check(dma_data == w_one(12'h401), "R6 held", dma_data, w_one(12'h401));
        mon_en = 1'b1;
        send(3, 12'h403);
        drain("R6");

        // R9: overrun on second result for a waiting converter
        tag = "R9";
        set_mode(2'b00);
        set_mode(2'b01);
        check(ovr == 1'b0, "R9 clear before", 32'(ovr), 32'd0);
        mon_en = 1'b0;
        push(w_one(12'h601)); push(w_one(12'h602));
        send(1, 12'h601); send(2, 12'h602); send(2, 12'h6FF);
        check(ovr == 1'b1, "R9 overrun set", 32'(ovr), 32'd1);
        mon_en = 1'b1;
        drain("R9");
        check(ovr == 1'b1, "R9 sticky", 32'(ovr), 32'd1);
        @(negedge clk); ovr_clr = 1'b1;
        @(negedge clk); ovr_clr = 1'b0;
        check(ovr == 1'b0, "R9 cleared", 32'(ovr), 32'd0);

        repeat (5) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule